// File: doc/BRIEF.md
# Timer DMA Burst Register Redirector

This block sits beside a timer's register file. It lets a single timer event start a burst of DMA transfers that all target one fixed bus address. That address is a virtual data port with no storage of its own. Each access to it is steered to a real timer register. The target moves up by one register for every transfer the DMA engine acknowledges. A DMA channel with a constant destination address can therefore rewrite a window of timer registers, or read one back, every time the event recurs.

The window is set by two configuration inputs, sampled when a burst starts:

- a base index, which selects the first register;
- a length field, which selects how many transfers the burst holds.

The burst is paced by a single request line. It stays high from the cycle after the event until the cycle after the last acknowledge. Each acknowledge consumes one transfer. Accesses to any other bus address go straight to the register with the same index.

Top module: `tim_burst_redirector`

## Requirements
- R1: After reset the request output is low, the transfer count is zero, and an access to the virtual address is steered to the index on the base configuration input.
- R2: An event pulse while no burst is running makes the request output high in the next cycle. The request stays high until the burst completes.
- R3: Transfer k of a burst (k counted from 0) is steered to register index base+k. Here base is the base index captured at the start of the burst. A write through the virtual address lands in that register with the value written.
- R4: The cycle after the acknowledge of the final transfer, the request output is low. A virtual access then goes back to the base index.
- R5: An event that arrives while a burst is running is ignored: the burst keeps its original number of transfers. A cycle in which the request is high but no acknowledge arrives leaves the target index unchanged.
- R6: The length field encodes the number of transfers minus one. A value of 0 gives 1 transfer, and 17 gives 18 transfers. Any value above 17 gives 18 transfers.
- R7: A read through the virtual address returns the contents of the register currently targeted. Over a burst, successive reads return consecutive registers in order.
- R8: A bus access to an address other than the virtual one (the virtual address is 32 at the default width) goes to the register whose index equals the address. It does not advance the burst.
- R9: Target indices wrap modulo the register count. With base 30 and 32 registers, the burst visits 30, 31, 0, 1, and so on.
- R10: An acknowledge while no request is pending has no effect. The request stays low and the index stays at the base.
- R11: Changing the base or length inputs during a burst does not alter that burst's targets or its number of transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 1 | Timer event that starts a burst |
| cfg_base_i | input | IDX_W | Index of the first register in the window |
| cfg_len_i | input | LEN_W | Transfers per burst minus one |
| dma_req_o | output | 1 | DMA request, high while transfers remain |
| dma_ack_i | input | 1 | DMA acknowledge, one transfer consumed per cycle high |
| bus_sel_i | input | 1 | Register bus access strobe |
| bus_wr_i | input | 1 | Register bus write (1) or read (0) |
| bus_addr_i | input | BUS_AW | Register bus address |
| bus_wdata_i | input | DATA_W | Register bus write data |
| bus_rdata_o | output | DATA_W | Register bus read data |
| rf_we_o | output | 1 | Register file write enable |
| rf_idx_o | output | IDX_W | Register file index |
| rf_wdata_o | output | DATA_W | Register file write data |
| rf_rdata_i | input | DATA_W | Register file read data at rf_idx_o |

## Verification
The bench builds the block with 16-bit data, a 32-entry register file, a 5-bit length field and a maximum of 18 transfers. With a 5-bit length field, the bench can drive values above 17, such as 25, which exercises the clamp to 18 transfers. Because the register file is small, a base of 30 makes a five-transfer burst wrap past index 31 back to 0. An 18-transfer burst from base 0 is still short enough to drive in full in both write and read form. A mid-burst direct access to a fixed register checks that the two access paths stay independent.

// File: rtl/tim_burst_redirector.sv
module tim_burst_redirector #(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter int LEN_W     = 5,
  parameter int MAX_LEN   = 18,
  parameter int BUS_AW    = IDX_W + 1,
  parameter int VIRT_ADDR = 2 ** IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic [IDX_W-1:0]  cfg_base_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  output logic              dma_req_o,
  input  logic              dma_ack_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_idx_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  input  logic [DATA_W-1:0] rf_rdata_i
);

  localparam logic [LEN_W-1:0]  LAST_CAP = LEN_W'(MAX_LEN - 1);
  localparam logic [BUS_AW-1:0] VADDR    = BUS_AW'(VIRT_ADDR);

  logic             busy_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] last_q;
  logic [IDX_W-1:0] base_q;

  wire start = evt_i && !busy_q;
  wire step  = busy_q && dma_ack_i;
  wire [LEN_W-1:0] last_sel = (cfg_len_i > LAST_CAP) ? LAST_CAP : cfg_len_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
      base_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      base_q <= cfg_base_i;
      last_q <= last_sel;
    end else if (step) begin
      if (cnt_q == last_q) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  wire [IDX_W-1:0] cur_base = busy_q ? base_q : cfg_base_i;
  wire [IDX_W-1:0] cur_idx  = cur_base + IDX_W'(cnt_q);
  wire             virt     = bus_addr_i == VADDR;

  assign dma_req_o   = busy_q;
  assign rf_idx_o    = virt ? cur_idx : bus_addr_i[IDX_W-1:0];
  assign rf_we_o     = bus_sel_i && bus_wr_i;
  assign rf_wdata_o  = bus_wdata_i;
  assign bus_rdata_o = rf_rdata_i;

endmodule

module tim_burst_redirector_chk #(
  parameter int LEN_W   = 5,
  parameter int MAX_LEN = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_i,
  input logic             dma_ack_i,
  input logic             dma_req_o,
  input logic [LEN_W-1:0] cnt_q
);

  a_r2_req_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !dma_req_o) |=> dma_req_o);

  a_r10_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req_o && !evt_i) |=> !dma_req_o);

  a_r5_hold_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_o && !dma_ack_i) |=> (dma_req_o && $stable(cnt_q)));

  a_r3_step_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_o && dma_ack_i) |=>
      ((cnt_q == LEN_W'($past(cnt_q) + 1'b1)) || (!dma_req_o && cnt_q == '0)));

  a_r4_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req_o |-> (cnt_q == '0));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LEN_W'(MAX_LEN - 1));

endmodule

bind tim_burst_redirector tim_burst_redirector_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .dma_ack_i(dma_ack_i),
  .dma_req_o(dma_req_o), .cnt_q(cnt_q)
);

// File: tb/tim_burst_redirector_bench.sv
module tim_burst_redirector_bench;
  localparam int DW = 16, IW = 5, LW = 5, ML = 18, AW = 6, VA = 32, NREG = 32;

  logic clk = 0, rst_n = 0;
  logic evt = 0, ack = 0, sel = 0, wr = 0;
  logic [IW-1:0] cfg_base = 0;
  logic [LW-1:0] cfg_len = 0;
  logic [AW-1:0] addr = 0;
  logic [DW-1:0] wdata = 0;
  logic dma_req_o, rf_we_o;
  logic [DW-1:0] bus_rdata_o, rf_wdata_o, rf_rdata_i;
  logic [IW-1:0] rf_idx_o;
  logic [DW-1:0] mem [NREG];

  int nchk = 0, nerr = 0;
  int exp_idx[$];
  int exp_dat[$];

  always #2 clk = ~clk;

  tim_burst_redirector #(.DATA_W(DW), .IDX_W(IW), .LEN_W(LW), .MAX_LEN(ML),
                         .BUS_AW(AW), .VIRT_ADDR(VA)) u_tim_burst_redirector (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .cfg_base_i(cfg_base), .cfg_len_i(cfg_len),
    .dma_req_o(dma_req_o), .dma_ack_i(ack), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(bus_rdata_o),
    .rf_we_o(rf_we_o), .rf_idx_o(rf_idx_o), .rf_wdata_o(rf_wdata_o), .rf_rdata_i(rf_rdata_i)
  );

  always_ff @(posedge clk) if (rf_we_o) mem[rf_idx_o] <= rf_wdata_o;
  assign rf_rdata_i = mem[rf_idx_o];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes
  always @(negedge clk) begin
    #1;
    if (rst_n && rf_we_o) begin
      if (exp_idx.size() == 0) chk(0, "R3 unexpected write idx", rf_idx_o, -1);
      else begin
        int ei, ed;
        ei = exp_idx.pop_front();
        ed = exp_dat.pop_front();
        chk(rf_idx_o == ei, "R3 write index", rf_idx_o, ei);
        chk(rf_wdata_o == ed, "R3 write data", rf_wdata_o, ed);
      end
    end
  end

  task automatic run_burst(input int base, input int lf, input int n, input bit w,
                           input bit mid_evt, input bit mid_cfg, input bit direct,
                           input int seed);
    @(negedge clk);
    cfg_base = IW'(base); cfg_len = LW'(lf); evt = 1;
    @(negedge clk);
    evt = 0;
    chk(dma_req_o == 1, "R2 request after event", dma_req_o, 1);
    for (int k = 0; k < n; k++) begin
      int ti;
      ti = (base + k) % NREG;
      ack = 1; sel = 1; wr = w; addr = AW'(VA); wdata = DW'(seed + k);
      if (mid_evt && k == 1) evt = 1;
      if (mid_cfg && k == 1) begin cfg_base = IW'(base + 7); cfg_len = 0; end
      if (w) begin
        exp_idx.push_back(ti); exp_dat.push_back(seed + k);
      end else begin
        #1;
        chk(rf_idx_o == IW'(ti), "R7 read index", rf_idx_o, ti);
        chk(bus_rdata_o == mem[ti], "R7 read data", bus_rdata_o, mem[ti]);
      end
      @(negedge clk);
      ack = 0; sel = 0; wr = 0; evt = 0;
      if (k < n - 1) begin
        chk(dma_req_o == 1, "R5 request held mid-burst", dma_req_o, 1);
        if (direct && k == 0) begin
          sel = 1; wr = 1; addr = 7; wdata = 16'h0707;
          exp_idx.push_back(7); exp_dat.push_back(16'h0707);
          @(negedge clk);
          sel = 0; wr = 0;
          chk(dma_req_o == 1, "R8 direct access leaves burst running", dma_req_o, 1);
        end
      end
    end
    chk(dma_req_o == 0, "R4 request low after final ack", dma_req_o, 0);
    addr = AW'(VA);
    #1;
    chk(rf_idx_o == cfg_base, "R4 index back at base", rf_idx_o, cfg_base);
    @(negedge clk);
    chk(dma_req_o == 0, "R6 no extra transfers", dma_req_o, 0);
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) mem[i] = DW'(16'hA000 + i);
    cfg_base = 5; addr = AW'(VA);
    #1;
    chk(dma_req_o == 0, "R1 request low in reset", dma_req_o, 0);
    chk(rf_idx_o == 5, "R1 virtual index at base", rf_idx_o, 5);
    repeat (3) @(negedge clk);
    rst_n = 1;

    run_burst(3, 3, 4, 1, 0, 0, 0, 16'h1100);
    for (int k = 0; k < 4; k++)
      chk(mem[3 + k] == DW'(16'h1100 + k), "R3 register contents", mem[3 + k], 16'h1100 + k);

    run_burst(12, 0, 1, 1, 0, 0, 0, 16'h2200);          // R6 single
    run_burst(0, 17, 18, 1, 0, 0, 0, 16'h3300);         // R6 max
    run_burst(8, 25, 18, 1, 0, 0, 0, 16'h4400);         // R6 clamp
    run_burst(30, 4, 5, 1, 0, 0, 0, 16'h5500);          // R9 wrap
    chk(mem[1] == DW'(16'h5503), "R9 wrapped register", mem[1], 16'h5503);
    run_burst(4, 2, 3, 1, 1, 0, 0, 16'h6600);           // R5 ignored event
    run_burst(20, 3, 4, 1, 0, 1, 0, 16'h7700);          // R11 config change
    run_burst(10, 2, 3, 1, 0, 0, 1, 16'h8800);          // R8 direct
    chk(mem[7] == 16'h0707, "R8 direct register", mem[7], 16'h0707);
    run_burst(0, 17, 18, 0, 0, 0, 0, 0);                // R7 reads

    @(negedge clk);
    cfg_base = 9; ack = 1;
    @(negedge clk);
    ack = 0;
    chk(dma_req_o == 0, "R10 stray ack ignored", dma_req_o, 0);
    addr = AW'(VA);
    #1;
    chk(rf_idx_o == 9, "R10 index stays at base", rf_idx_o, 9);

    repeat (3) @(negedge clk);
    chk(exp_idx.size() == 0, "R3 all expected writes seen", exp_idx.size(), 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule